// File: doc/BRIEF.md
# Line Burst Bus Master

This block sits between an internal requester and a 32-bit external memory bus. It turns one request for a 16-byte line into a sequence of bus beats and drives all the bus signals: address, data out, read/write, a one-clock start strobe, a transfer-in-progress flag, a two-bit size code, chip select, byte selects and output enable. For a write, the requester hands over the whole line at once. For a read, the four captured words come back together with a one-clock done pulse.

Three settings are sampled when a request is accepted. The first picks the termination mode. In internal mode each beat lasts a programmed number of wait clocks. In external mode each beat lasts until the acknowledge input is seen high. The second setting picks the transfer shape. A true burst takes one address phase followed by four data beats, which gives 2-1-1-1 clocks with no wait states. In the burst-inhibited shape the line becomes four separate longword accesses, each with its own start strobe. The third setting is the wait count.

Top module: `line_burst_ctrl`

## Requirements
- R1: After synchronous reset, these outputs are low: start strobe, transfer-in-progress, chip select, output enable, data drive enable, busy and done. The byte selects are all zero and the size code is 00.
- R2: A request is accepted only when `busy` is low. On the clock after acceptance, the start strobe, transfer-in-progress and chip select are high, `busy` is high, `bus_rw` is 1 for a read, and the address is the line base with bits [3:0] equal to zero. The mode, shape and wait-count inputs take effect only at acceptance. A request raised while `busy` is high is ignored.
- R3: The start strobe is high for exactly one clock per access. A true burst has one strobe and a burst-inhibited line has four.
- R4: The size code is 11 (line) for a true burst and 00 (longword) for every access in the burst-inhibited shape.
- R5: In internal mode with wait count W, done rises 1+4(W+1) clocks after the start-strobe clock for a burst (2-1-1-1 when W=0). For the inhibited shape it rises 4(W+2) clocks after.
- R6: For writes, data is driven with `bus_dout_en` high in the clock after the start strobe. Word i of `req_wdata` (bits [32i+31:32i]) is on `bus_dout` during beat i. `bus_dout_en` is high only in write data beats.
- R7: Chip select and transfer-in-progress stay high from the first strobe through the last beat. Both are low in the done clock.
- R8: In external mode, and in every inhibited access, address bits [3:2] equal the beat index 0,1,2,3 in order. In an internal-mode burst the address stays at the line base.
- R9: In external mode a beat ends only at a clock edge where `bus_ack` is high. Clocks without acknowledge extend the beat. In internal mode `bus_ack` has no effect.
- R10: Output enable is high only in read data beats. The word sampled on `bus_din` at the end of beat i appears in `rd_line` bits [32i+31:32i] when done is high.
- R11: Done is a one-clock pulse. During that clock `busy` and transfer-in-progress are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Line request |
| req_write | input | 1 | 1 = line write, 0 = line read |
| req_line | input | AW-4 | Line number (address bits [AW-1:4]) |
| req_wdata | input | 128 | Line to write, word i in bits [32i+31:32i] |
| cfg_ext_term | input | 1 | 1 = wait for acknowledge, 0 = internal wait count |
| cfg_burst_off | input | 1 | 1 = four separate longword accesses |
| cfg_wait | input | WW | Internal wait clocks per beat |
| busy | output | 1 | Line in progress |
| done | output | 1 | One-clock completion pulse |
| rd_line | output | 128 | Captured read words |
| bus_addr | output | AW | Bus address |
| bus_siz | output | 2 | Size code: 11 line, 00 longword |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_ts | output | 1 | Start strobe |
| bus_tip | output | 1 | Transfer in progress |
| bus_cs | output | 1 | Chip select, active high |
| bus_be | output | 4 | Byte selects |
| bus_oe | output | 1 | Output enable for memory read |
| bus_dout | output | 32 | Write data |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | 32 | Read data |
| bus_ack | input | 1 | Transfer acknowledge |

## Verification
The bench holds acknowledge low for random stretches in external mode. A design that ends beats without acknowledge would then shift the address index and the captured words relative to the bench's beat count. It also toggles acknowledge in internal mode and scrambles the settings right after acceptance. A design that reads these live would end up with wrong cycle counts, address stepping or size codes. Runs that raise requests mid-burst catch a design that restarts on a second request. Wait counts from 0 to 3 in both shapes catch off-by-one errors in the 2-1-1-1 and inhibited timing, and they catch write data that is driven one beat late.

// File: rtl/line_burst_pkg.sv
package line_burst_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  localparam logic [1:0] SIZ_LONG = 2'b00;
  localparam logic [1:0] SIZ_LINE = 2'b11;
endpackage

// File: rtl/lb_wait_timer.sv
module lb_wait_timer #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_data,
  input  logic          ext_mode,
  input  logic          ack,
  input  logic [WW-1:0] limit,
  output logic          beat_end
);
  logic [WW-1:0] cnt_q;

  // a beat ends on acknowledge (external) or when the wait budget is used up
  assign beat_end = in_data && (ext_mode ? ack : (cnt_q == limit));

  always_ff @(posedge clk) begin
    if (rst || !in_data || beat_end) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lb_rd_buf.sv
module lb_rd_buf #(
  parameter int DW    = 32,
  parameter int WORDS = 4,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [DW-1:0]       wr_data,
  output logic [WORDS*DW-1:0] line
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)                                word_q <= '0;
      else if (wr_en && wr_idx == IW'(g))     word_q <= wr_data;
    end
    assign line[g*DW +: DW] = word_q;
  end
endmodule

// File: rtl/lb_seq.sv
module lb_seq
  import line_burst_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 4,
  parameter int WW    = 4,
  localparam int BE   = DW / 8,
  localparam int OFS  = $clog2(BE),
  localparam int IW   = $clog2(WORDS),
  localparam int LB   = OFS + IW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [AW-LB-1:0]    req_line,
  input  logic [WORDS*DW-1:0] req_wdata,
  input  logic                cfg_ext_term,
  input  logic                cfg_burst_off,
  input  logic [WW-1:0]       cfg_wait,
  input  logic                beat_end,
  output logic                in_data,
  output logic                mode_ext,
  output logic [WW-1:0]       wait_lim,
  output logic                cap_en,
  output logic [IW-1:0]       cap_idx,
  output logic [AW-1:0]       bus_addr,
  output logic [1:0]          bus_siz,
  output logic                bus_rw,
  output logic                bus_ts,
  output logic                bus_tip,
  output logic                bus_cs,
  output logic [BE-1:0]       bus_be,
  output logic                bus_oe,
  output logic [DW-1:0]       bus_dout,
  output logic                bus_dout_en,
  output logic                done,
  output logic                busy
);
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  phase_t              phase_q;
  logic [IW-1:0]       beat_q;
  logic                wr_q, inh_q;
  logic [AW-LB-1:0]    line_q;
  logic [WORDS*DW-1:0] wline_q;
  logic [IW-1:0]       nxt;

  assign nxt      = beat_q + 1'b1;
  assign in_data  = (phase_q == PH_DATA);
  assign cap_en   = in_data && beat_end && !wr_q;
  assign cap_idx  = beat_q;

  function automatic logic [AW-1:0] beat_addr(input logic [AW-LB-1:0] ln,
                                               input logic [IW-1:0] idx);
    return {ln, idx, {OFS{1'b0}}};
  endfunction

  function automatic logic [DW-1:0] pick(input logic [WORDS*DW-1:0] ln,
                                         input logic [IW-1:0] idx);
    return ln[int'(idx)*DW +: DW];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      beat_q      <= '0;
      wr_q        <= 1'b0;
      inh_q       <= 1'b0;
      mode_ext    <= 1'b0;
      wait_lim    <= '0;
      line_q      <= '0;
      wline_q     <= '0;
      bus_addr    <= '0;
      bus_siz     <= SIZ_LONG;
      bus_rw      <= 1'b0;
      bus_ts      <= 1'b0;
      bus_tip     <= 1'b0;
      bus_cs      <= 1'b0;
      bus_be      <= '0;
      bus_oe      <= 1'b0;
      bus_dout    <= '0;
      bus_dout_en <= 1'b0;
      done        <= 1'b0;
      busy        <= 1'b0;
    end else begin
      bus_ts <= 1'b0;
      done   <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (req_valid) begin
          phase_q  <= PH_ADDR;
          beat_q   <= '0;
          wr_q     <= req_write;
          inh_q    <= cfg_burst_off;
          mode_ext <= cfg_ext_term;
          wait_lim <= cfg_wait;
          line_q   <= req_line;
          wline_q  <= req_wdata;
          bus_addr <= beat_addr(req_line, '0);
          bus_siz  <= cfg_burst_off ? SIZ_LONG : SIZ_LINE;
          bus_rw   <= !req_write;
          bus_ts   <= 1'b1;
          bus_tip  <= 1'b1;
          bus_cs   <= 1'b1;
          bus_be   <= '1;
          busy     <= 1'b1;
        end
        PH_ADDR: begin
          phase_q     <= PH_DATA;
          bus_dout    <= pick(wline_q, beat_q);
          bus_dout_en <= wr_q;
          bus_oe      <= !wr_q;
        end
        PH_DATA: if (beat_end) begin
          if (beat_q == LAST) begin
            phase_q     <= PH_IDLE;
            bus_tip     <= 1'b0;
            bus_cs      <= 1'b0;
            bus_be      <= '0;
            bus_oe      <= 1'b0;
            bus_dout_en <= 1'b0;
            bus_rw      <= 1'b0;
            bus_addr    <= '0;
            bus_siz     <= SIZ_LONG;
            busy        <= 1'b0;
            done        <= 1'b1;
          end else begin
            beat_q <= nxt;
            if (inh_q) begin
              // separate longword access: new strobe, new address
              phase_q     <= PH_ADDR;
              bus_ts      <= 1'b1;
              bus_addr    <= beat_addr(line_q, nxt);
              bus_oe      <= 1'b0;
              bus_dout_en <= 1'b0;
            end else begin
              bus_dout <= pick(wline_q, nxt);
              if (mode_ext) bus_addr <= beat_addr(line_q, nxt);
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/line_burst_ctrl.sv
module line_burst_ctrl #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 4,
  parameter int WW    = 4
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     req_valid,
  input  logic                                     req_write,
  input  logic [AW-$clog2(DW/8)-$clog2(WORDS)-1:0] req_line,
  input  logic [WORDS*DW-1:0]                      req_wdata,
  input  logic                                     cfg_ext_term,
  input  logic                                     cfg_burst_off,
  input  logic [WW-1:0]                            cfg_wait,
  output logic                                     busy,
  output logic                                     done,
  output logic [WORDS*DW-1:0]                      rd_line,
  output logic [AW-1:0]                            bus_addr,
  output logic [1:0]                               bus_siz,
  output logic                                     bus_rw,
  output logic                                     bus_ts,
  output logic                                     bus_tip,
  output logic                                     bus_cs,
  output logic [DW/8-1:0]                          bus_be,
  output logic                                     bus_oe,
  output logic [DW-1:0]                            bus_dout,
  output logic                                     bus_dout_en,
  input  logic [DW-1:0]                            bus_din,
  input  logic                                     bus_ack
);
  localparam int IW = $clog2(WORDS);

  logic          in_data, mode_ext, beat_end, cap_en;
  logic [WW-1:0] wait_lim;
  logic [IW-1:0] cap_idx;

  lb_seq #(.AW(AW), .DW(DW), .WORDS(WORDS), .WW(WW)) u_seq (
    .clk, .rst, .req_valid, .req_write, .req_line, .req_wdata,
    .cfg_ext_term, .cfg_burst_off, .cfg_wait, .beat_end,
    .in_data, .mode_ext, .wait_lim, .cap_en, .cap_idx,
    .bus_addr, .bus_siz, .bus_rw, .bus_ts, .bus_tip, .bus_cs, .bus_be,
    .bus_oe, .bus_dout, .bus_dout_en, .done, .busy
  );

  lb_wait_timer #(.WW(WW)) u_timer (
    .clk, .rst, .in_data, .ext_mode(mode_ext), .ack(bus_ack),
    .limit(wait_lim), .beat_end
  );

  lb_rd_buf #(.DW(DW), .WORDS(WORDS)) u_rbuf (
    .clk, .rst, .wr_en(cap_en), .wr_idx(cap_idx), .wr_data(bus_din),
    .line(rd_line)
  );
endmodule

// File: rtl/line_burst_sva.sv
module line_burst_sva (
  input logic clk,
  input logic rst,
  input logic bus_ts,
  input logic bus_tip,
  input logic bus_cs,
  input logic bus_oe,
  input logic bus_rw,
  input logic bus_dout_en,
  input logic done,
  input logic busy
);
  AST_TS_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    bus_ts |=> !bus_ts); // R3
  AST_CS_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_tip |-> bus_cs); // R7
  AST_WDATA_AFTER_TS: assert property (@(posedge clk) disable iff (rst)
    (bus_ts && !bus_rw) |=> bus_dout_en); // R6
  AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (rst)
    bus_dout_en |-> (!bus_oe && !bus_rw)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_tip && !busy)); // R11
endmodule

bind line_burst_ctrl line_burst_sva u_sva (
  .clk(clk), .rst(rst), .bus_ts(bus_ts), .bus_tip(bus_tip), .bus_cs(bus_cs),
  .bus_oe(bus_oe), .bus_rw(bus_rw), .bus_dout_en(bus_dout_en),
  .done(done), .busy(busy)
);

// File: tb/line_burst_ctrl_tb.sv
module line_burst_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid, req_write, cfg_ext_term, cfg_burst_off;
  logic [27:0]  req_line;
  logic [127:0] req_wdata;
  logic [3:0]   cfg_wait;
  logic         busy, done;
  logic [127:0] rd_line;
  logic [31:0]  bus_addr, bus_dout, bus_din;
  logic [1:0]   bus_siz;
  logic         bus_rw, bus_ts, bus_tip, bus_cs, bus_oe, bus_dout_en, bus_ack;
  logic [3:0]   bus_be;

  int errors = 0;
  int checks = 0;
  int tick = 0;

  line_burst_ctrl u_dut (
    .clk, .rst, .req_valid, .req_write, .req_line, .req_wdata,
    .cfg_ext_term, .cfg_burst_off, .cfg_wait, .busy, .done, .rd_line,
    .bus_addr, .bus_siz, .bus_rw, .bus_ts, .bus_tip, .bus_cs, .bus_be,
    .bus_oe, .bus_dout, .bus_dout_en, .bus_din, .bus_ack
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    tick++;
    if (tick > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", tick, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int i);
    return base | (32'(i) << 2);
  endfunction

  function automatic int exp_cycles(input bit inh, input int w);
    return inh ? 4 * (w + 2) : 1 + 4 * (w + 1);
  endfunction

  task automatic run_line(input bit wr, input bit ext, input bit inh,
                          input int w, input bit jam);
    logic [31:0]  base;
    logic [31:0]  rexp [4];
    logic [127:0] wline;
    int k = 0, wc = 0, nts = 0, idx = 0;
    bit prev_ts = 0, seen = 0, endb;
    base  = {$urandom()} & 32'hFFFF_FFF0;
    wline = {$urandom(), $urandom(), $urandom(), $urandom()};
    for (int i = 0; i < 4; i++) rexp[i] = $urandom();
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_line = base[31:4]; req_wdata = wline;
    cfg_ext_term = ext; cfg_burst_off = inh; cfg_wait = 4'(w);
    @(negedge clk);
    req_valid = 1'b0;
    // settings change after acceptance must not matter (R2)
    cfg_ext_term = $urandom(); cfg_burst_off = $urandom(); cfg_wait = $urandom();
    check(bus_ts && bus_tip && bus_cs && busy, "R2 start", {bus_ts, bus_tip, bus_cs, busy}, 4'hF);
    check(bus_addr == base, "R2 base addr", bus_addr, base);
    check(bus_rw == !wr, "R2 rw", bus_rw, !wr);
    while (!seen && idx < 400) begin
      if (done) begin
        seen = 1;
        check(!busy && !bus_tip && !bus_cs, "R11/R7 done clock", {busy, bus_tip, bus_cs}, 0);
        check(k == 4, "R9 beat count", k, 4);
        check(nts == (inh ? 4 : 1), "R3 strobe count", nts, inh ? 4 : 1);
        if (!ext) check(idx == exp_cycles(inh, w), "R5 cycles", idx, exp_cycles(inh, w));
        if (!wr) check(rd_line == {rexp[3], rexp[2], rexp[1], rexp[0]}, "R10 rd_line",
                       rd_line, {rexp[3], rexp[2], rexp[1], rexp[0]});
      end else begin
        check(bus_tip && bus_cs && busy, "R7 held", {bus_tip, bus_cs, busy}, 3'h7);
        check(bus_siz == (inh ? 2'b00 : 2'b11), "R4 size", bus_siz, inh ? 2'b00 : 2'b11);
        endb = 0;
        bus_ack = $urandom();
        bus_din = rexp[k < 4 ? k : 0];
        if (bus_ts) begin
          nts++;
          check(bus_addr == exp_addr(base, nts - 1), "R8 strobe addr", bus_addr,
                exp_addr(base, nts - 1));
          check(!bus_oe && !bus_dout_en, "R6 no drive in strobe", {bus_oe, bus_dout_en}, 0);
        end else begin
          if (prev_ts && wr) check(bus_dout_en, "R6 data after strobe", bus_dout_en, 1);
          check(bus_dout_en == wr && bus_oe == !wr, "R6/R10 drive", {bus_dout_en, bus_oe}, {wr, !wr});
          check(bus_addr == ((ext || inh) ? exp_addr(base, k) : base), "R8 beat addr",
                bus_addr, (ext || inh) ? exp_addr(base, k) : base);
          endb = ext ? bus_ack : (wc == w);
          if (wr && endb) check(bus_dout == wline[k*32 +: 32], "R6 write word", bus_dout,
                                wline[k*32 +: 32]);
          if (endb) begin k++; wc = 0; end else wc++;
        end
        prev_ts = bus_ts;
        req_valid = jam && (k < 3);
        req_line = $urandom();
        @(negedge clk);
        idx++;
      end
    end
    req_valid = 1'b0;
    check(seen, "R11 done seen", seen, 1);
    @(negedge clk);
    check(!done && !busy && !bus_tip, "R11 pulse end", {done, busy, bus_tip}, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; req_valid = 0; req_write = 0; req_line = '0; req_wdata = '0;
    cfg_ext_term = 0; cfg_burst_off = 0; cfg_wait = '0; bus_din = '0; bus_ack = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!bus_ts && !bus_tip && !bus_cs && !bus_oe && !bus_dout_en && !busy && !done,
          "R1 reset", {bus_ts, bus_tip, bus_cs, bus_oe, bus_dout_en, busy, done}, 0);
    check(bus_be == 4'h0 && bus_siz == 2'b00, "R1 reset be/siz", {bus_be, bus_siz}, 0);
    // directed corner cases
    run_line(1, 0, 0, 0, 0);   // 2-1-1-1 write, R5
    run_line(0, 0, 0, 0, 0);   // 2-1-1-1 read
    run_line(0, 0, 1, 0, 0);   // inhibited read, R3
    run_line(1, 1, 0, 0, 1);   // external write with request jam, R2/R9
    run_line(0, 1, 1, 0, 1);   // external inhibited read
    run_line(1, 0, 1, 3, 0);   // inhibited write, max wait tested
    run_line(0, 0, 0, 15, 1);  // largest wait count
    for (int n = 0; n < 40; n++)
      run_line($urandom(), $urandom(), $urandom(), $urandom_range(0, 3), $urandom());
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule